// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block decides, row by row, which DRAM rows receive a refresh command, so that rows with long charge retention are refreshed less often than the few rows that leak quickly. A refresh period is split into four equal epochs. A row pointer walks through every row once per epoch, taking one slot per row. In each slot the current row is tested against two set-membership filters:

- The fast filter holds the weakest rows. They are refreshed in every epoch.
- The medium filter holds rows of moderate retention. They are refreshed in every second epoch.
- Every other row is refreshed only in the first epoch of the period.

Each filter is a bit vector with three hash functions. A profiling agent adds rows to a filter through the insert port. A clear input empties both filters.

A due row is issued as a refresh command that carries the row address. The command is held until the memory side acknowledges it, and only then does the pointer move on. A row that is not due is skipped at the end of its slot and produces no command. A row may be reported as present when it was never inserted. This only causes an extra refresh. A row that was inserted is never missed, and the filters cannot overflow.

Top module: `retention_refresh_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycles after its release, `ref_req` is low and `ref_row` is 0. The first command, for row 0, rises exactly SLOT_CYCLES clock edges after the first edge with `rst` low.
- R2: The slot timing is as follows. After an acknowledge, the next command rises exactly (s+1)*SLOT_CYCLES edges later, where s is the number of rows skipped as not due in between.
- R3: Epochs are numbered 0 to 3, and epoch 0 starts at reset. In epoch 0 every row is issued, in ascending row order.
- R4: A row that tests present in the fast filter (`ins_bin` = 0) is issued in every epoch.
- R5: A row that tests present only in the medium filter (`ins_bin` = 1) is issued in epochs 0 and 2 and skipped in epochs 1 and 3. When a row is present in both filters, the fast rule applies.
- R6: An insert of row r into a filter sets the three filter bits at indices h0(r), h1(r) and h2(r). A row tests present only when all three of its bits are set, so an inserted row is never skipped by its bin's rule. The hashes work as follows:
  - With I = log2(FILT_BITS), the row is zero-extended and cut into I-bit slices, with slice 0 holding the least significant bits.
  - For hash k (k = 0, 1, 2), slice j is rotated left by (j*(2k+1)) mod I.
  - The rotated slices are XORed together with the constant (37k+11) mod FILT_BITS.
- R7: A cycle with `clr` high empties both filters. An insert in that same cycle is lost.
- R8: `ref_req` and `ref_row` stay unchanged until `ref_done` is seen high on a clock edge. Inserts made meanwhile do not disturb the pending command.
- R9: `ref_done` is ignored while no command is pending. It changes neither the row pointer nor the slot timing.
- R10: After the last row the pointer wraps to row 0 and the epoch number advances. After epoch 3 it returns to epoch 0, so row 0 is issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert strobe for a profiled row |
| ins_bin | input | 1 | Target filter: 0 = fast (every epoch), 1 = medium (every second epoch) |
| ins_row | input | ROW_W | Row address to insert |
| clr | input | 1 | Empty both filters |
| ref_done | input | 1 | Acknowledge of the pending refresh command |
| ref_req | output | 1 | Refresh command pending |
| ref_row | output | ROW_W | Row address of the pending command |

## Verification
The bench builds the block with ROW_W = 8, FILT_BITS = 64 and SLOT_CYCLES = 3. With these values a full four-epoch period of 256 rows takes only a few thousand cycles, so wraps of both the row pointer and the epoch number are reached several times. A 6-bit filter index cut from two row slices makes the hashes non-trivial. A 64-bit filter holding around a dozen rows produces some false positives, so the bench must predict extra refreshes from its own filter model. The bench also clears the filters in the middle of a period, which brings within reach a stretch of three epochs with no command at all.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    localparam int NUM_HASH = 3;
    localparam int NUM_BINS = 2;
    localparam int BIN_FAST = 0;
    localparam int BIN_MID  = 1;
    localparam int EPOCH_W  = 2;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_REQ  = 1'b1
    } sched_st_e;

    typedef struct packed {
        logic fast;
        logic mid;
    } bin_hits_t;

    // Constant folded into hash k.
    function automatic int unsigned hash_salt(input int unsigned k);
        return 37 * k + 11;
    endfunction

    // Left rotation applied to slice j inside hash k, for an index of width w.
    function automatic int unsigned hash_rot(input int unsigned j,
                                             input int unsigned k,
                                             input int unsigned w);
        return (j * (2 * k + 1)) % w;
    endfunction

    // Decides whether a row is refreshed in a given epoch of the period.
    function automatic logic epoch_due(input bin_hits_t h, input logic [EPOCH_W-1:0] ep);
        return (ep == '0) | h.fast | (h.mid & ~ep[0]);
    endfunction

endpackage

// File: rtl/rrf_hash.sv
module rrf_hash
    import rrf_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int IDX_W = 8
) (
    input  logic [ROW_W-1:0]                row,
    output logic [NUM_HASH-1:0][IDX_W-1:0]  idx
);

    localparam int NSLICE = (ROW_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NSLICE * IDX_W;

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(row);

    function automatic logic [IDX_W-1:0] rotl(input logic [IDX_W-1:0] v, input int unsigned r);
        return (v << r) | (v >> (IDX_W - r));
    endfunction

    always_comb begin
        for (int unsigned k = 0; k < NUM_HASH; k++) begin
            logic [IDX_W-1:0] acc;
            acc = IDX_W'(hash_salt(k));
            for (int unsigned j = 0; j < NSLICE; j++) begin
                acc = acc ^ rotl(padded[j*IDX_W +: IDX_W], hash_rot(j, k, IDX_W));
            end
            idx[k] = acc;
        end
    end

endmodule

// File: rtl/rrf_bloom.sv
module rrf_bloom
    import rrf_pkg::*;
#(
    parameter int ROW_W     = 14,
    parameter int FILT_BITS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins_en,
    input  logic [ROW_W-1:0] ins_row,
    input  logic [ROW_W-1:0] tst_row,
    output logic             hit
);

    localparam int IDX_W = $clog2(FILT_BITS);

    logic [FILT_BITS-1:0]              bits;
    logic [NUM_HASH-1:0][IDX_W-1:0]    ins_idx;
    logic [NUM_HASH-1:0][IDX_W-1:0]    tst_idx;

    rrf_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W)) i_ins_hash (
        .row (ins_row),
        .idx (ins_idx)
    );

    rrf_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W)) i_tst_hash (
        .row (tst_row),
        .idx (tst_idx)
    );

    // Clearing takes precedence over a same-cycle insert.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits <= '0;
        end else if (ins_en) begin
            for (int k = 0; k < NUM_HASH; k++) begin
                bits[ins_idx[k]] <= 1'b1;
            end
        end
    end

    always_comb begin
        hit = 1'b1;
        for (int k = 0; k < NUM_HASH; k++) begin
            hit = hit & bits[tst_idx[k]];
        end
    end

endmodule

// File: rtl/rrf_sched.sv
module rrf_sched
    import rrf_pkg::*;
#(
    parameter int ROW_W       = 14,
    parameter int SLOT_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  bin_hits_t          hits,
    input  logic               ref_done,
    output logic               ref_req,
    output logic [ROW_W-1:0]   ref_row,
    output logic [EPOCH_W-1:0] epoch_cur,
    output logic               slot_last
);

    localparam int CNT_W = $clog2(SLOT_CYCLES + 1);

    sched_st_e          state;
    logic [CNT_W-1:0]   tmr;
    logic [ROW_W-1:0]   row_ptr;
    logic [EPOCH_W-1:0] epoch;
    logic               due;
    logic               advance;

    assign slot_last = (state == ST_WAIT) && (tmr == CNT_W'(SLOT_CYCLES - 1));
    assign due       = epoch_due(hits, epoch);
    assign advance   = (slot_last && !due) || (state == ST_REQ && ref_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT;
            tmr     <= '0;
            row_ptr <= '0;
            epoch   <= '0;
        end else if (advance) begin
            row_ptr <= row_ptr + 1'b1;
            if (row_ptr == '1) begin
                epoch <= epoch + 1'b1;
            end
            tmr   <= '0;
            state <= ST_WAIT;
        end else if (slot_last) begin
            state <= ST_REQ;
        end else if (state == ST_WAIT) begin
            tmr <= tmr + 1'b1;
        end
    end

    assign ref_req   = (state == ST_REQ);
    assign ref_row   = row_ptr;
    assign epoch_cur = epoch;

endmodule

// File: rtl/retention_refresh_ctrl.sv
module retention_refresh_ctrl
    import rrf_pkg::*;
#(
    parameter int ROW_W       = 14,
    parameter int FILT_BITS   = 256,
    parameter int SLOT_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic             ins_bin,
    input  logic [ROW_W-1:0] ins_row,
    input  logic             clr,
    input  logic             ref_done,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row
);

    logic [NUM_BINS-1:0] hit_vec;
    bin_hits_t           hits;
    logic [EPOCH_W-1:0]  epoch_cur;
    logic                slot_last;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        rrf_bloom #(.ROW_W(ROW_W), .FILT_BITS(FILT_BITS)) i_filter (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .ins_en  (ins_valid && (ins_bin == 1'(b))),
            .ins_row (ins_row),
            .tst_row (ref_row),
            .hit     (hit_vec[b])
        );
    end

    assign hits.fast = hit_vec[BIN_FAST];
    assign hits.mid  = hit_vec[BIN_MID];

    rrf_sched #(.ROW_W(ROW_W), .SLOT_CYCLES(SLOT_CYCLES)) i_sched (
        .clk       (clk),
        .rst       (rst),
        .hits      (hits),
        .ref_done  (ref_done),
        .ref_req   (ref_req),
        .ref_row   (ref_row),
        .epoch_cur (epoch_cur),
        .slot_last (slot_last)
    );

endmodule

// File: rtl/retention_refresh_chk.sv
module retention_refresh_chk
    import rrf_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                clr,
    input logic                ref_req,
    input logic                ref_done,
    input logic [ROW_W-1:0]    ref_row,
    input logic                slot_last,
    input logic [EPOCH_W-1:0]  epoch_cur,
    input logic [NUM_BINS-1:0] hit_vec
);

    assert_hold_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_done) |=> (ref_req && $stable(ref_row)));

    assert_ack_step_R10: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_done) |=> (!ref_req && ref_row == ROW_W'($past(ref_row) + 1'b1)));

    assert_epoch_step_R10: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_done && ref_row == '1) |=> (epoch_cur == EPOCH_W'($past(epoch_cur) + 1'b1)));

    assert_first_epoch_all_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_last && epoch_cur == '0) |=> ref_req);

    assert_fast_every_epoch_R4: assert property (@(posedge clk) disable iff (rst)
        (slot_last && hit_vec[BIN_FAST]) |=> ref_req);

    assert_mid_odd_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_last && !hit_vec[BIN_FAST] && hit_vec[BIN_MID] && epoch_cur[0]) |=> !ref_req);

    assert_stray_done_R9: assert property (@(posedge clk) disable iff (rst)
        (!ref_req && ref_done && !slot_last) |=> $stable(ref_row));

    assert_clear_empty_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hit_vec == '0));

endmodule

bind retention_refresh_ctrl retention_refresh_chk #(.ROW_W(ROW_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .ref_req   (ref_req),
    .ref_done  (ref_done),
    .ref_row   (ref_row),
    .slot_last (slot_last),
    .epoch_cur (epoch_cur),
    .hit_vec   (hit_vec)
);

// File: tb/test_retention_refresh_ctrl.sv
`timescale 1ns/1ps
module test_retention_refresh_ctrl;

    localparam int ROW_W     = 8;
    localparam int FILT_BITS = 64;
    localparam int SLOT      = 3;
    localparam int IDX_W     = 6;
    localparam int ROWS      = 256;
    localparam int NSL       = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             ins_valid;
    logic             ins_bin;
    logic [ROW_W-1:0] ins_row;
    logic             clr;
    logic             ref_done;
    logic             ref_req;
    logic [ROW_W-1:0] ref_row;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit mbits   [2][FILT_BITS];
    bit ins_set [2][ROWS];
    bit snap    [2][ROWS];
    bit seen    [ROWS];
    int cur_row, cur_epoch, period;

    always #10 clk = ~clk;

    retention_refresh_ctrl #(.ROW_W(ROW_W), .FILT_BITS(FILT_BITS), .SLOT_CYCLES(SLOT))
        i_retention_refresh_ctrl (
            .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_bin(ins_bin),
            .ins_row(ins_row), .clr(clr), .ref_done(ref_done),
            .ref_req(ref_req), .ref_row(ref_row));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hash k of a row, computed from the rule in R6.
    function automatic int bhash(input int row, input int k);
        int acc = (37 * k + 11) % FILT_BITS;
        for (int j = 0; j < NSL; j++) begin
            int sl = (row >> (j * IDX_W)) & (FILT_BITS - 1);
            int r  = (j * (2 * k + 1)) % IDX_W;
            acc = acc ^ (((sl << r) | (sl >> (IDX_W - r))) & (FILT_BITS - 1));
        end
        return acc;
    endfunction

    function automatic bit mtest(input int b, input int row);
        bit h = 1;
        for (int k = 0; k < 3; k++) h = h & mbits[b][bhash(row, k)];
        return h;
    endfunction

    function automatic bit mdue(input int row, input int ep);
        return (ep == 0) || mtest(0, row) || (mtest(1, row) && (ep % 2 == 0));
    endfunction

    // R6: every row inserted before the epoch began was issued when its bin required it.
    task automatic epoch_end();
        int miss = -1;
        for (int r = 0; r < ROWS; r++) begin
            if (snap[0][r] && !seen[r]) miss = r;
            if (snap[1][r] && (cur_epoch % 2 == 0) && !seen[r]) miss = r;
        end
        chk(miss < 0, "R6 inserted row missing in epoch", miss, -1);
        for (int r = 0; r < ROWS; r++) begin
            snap[0][r] = ins_set[0][r];
            snap[1][r] = ins_set[1][r];
            seen[r]    = 0;
        end
    endtask

    task automatic next_due(output int skips);
        skips = 0;
        forever begin
            cur_row++;
            if (cur_row == ROWS) begin
                epoch_end();
                cur_row   = 0;
                cur_epoch = (cur_epoch + 1) % 4;
                if (cur_epoch == 0) period++;
            end
            if (mdue(cur_row, cur_epoch)) break;
            skips++;
        end
    endtask

    task automatic do_insert(input int b, input int row);
        ins_valid = 1'b1;
        ins_bin   = b[0];
        ins_row   = row[ROW_W-1:0];
        @(posedge clk);
        for (int k = 0; k < 3; k++) mbits[b][bhash(row, k)] = 1;
        ins_set[b][row] = 1;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    // R7: clear together with an insert that must be lost.
    task automatic do_clear_ins(input int row);
        clr       = 1'b1;
        ins_valid = 1'b1;
        ins_bin   = 1'b0;
        ins_row   = row[ROW_W-1:0];
        @(posedge clk);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < FILT_BITS; i++) mbits[b][i] = 0;
            for (int r = 0; r < ROWS; r++) begin
                ins_set[b][r] = 0;
                snap[b][r]    = 0;
            end
        end
        @(negedge clk);
        clr       = 1'b0;
        ins_valid = 1'b0;
    endtask

    initial begin
        int  served = 0;
        bit  done_run = 0;
        bit  cleared = 0;
        void'($urandom(32'h1d5e));
        rst = 1'b1; ins_valid = 1'b0; ins_bin = 1'b0; ins_row = '0; clr = 1'b0; ref_done = 1'b0;
        cur_row = ROWS - 1; cur_epoch = 3; period = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ref_req == 1'b0, "R1 no request in reset", ref_req, 0);
        chk(ref_row == '0, "R1 row pointer at reset", ref_row, 0);
        rst = 1'b0;
        while (!done_run) begin
            int    skips, n, limit, hold_row, exp_gap;
            bit    stray, ok;
            string gtag, rtag;
            next_due(skips);
            exp_gap = (skips + 1) * SLOT;
            limit   = exp_gap + 4;
            n = 0; stray = 0;
            do begin
                @(posedge clk); n++;
                @(negedge clk);
                if (ref_req) break;
                if ($urandom % 8 == 0) begin ref_done = 1'b1; stray = 1; end
                else ref_done = 1'b0;
            end while (n < limit);
            ref_done = 1'b0;
            if (served == 0)        gtag = "R1 first command timing";
            else if (skips >= ROWS) gtag = "R7 gap after clear";
            else if (stray)         gtag = "R9 gap with stray ack";
            else                    gtag = "R2 slot gap";
            chk(ref_req && n == exp_gap, gtag, n, exp_gap);
            if (!ref_req) begin
                done_run = 1;
            end else begin
                if (served == 0)                          rtag = "R1 first row";
                else if (cur_row == 0 && cur_epoch == 0)  rtag = "R10 wrap to row 0 epoch 0";
                else if (cur_epoch == 0)                  rtag = "R3 epoch 0 row order";
                else if (mtest(0, cur_row))               rtag = "R4 fast bin row";
                else                                      rtag = "R5 medium bin row";
                chk(int'(ref_row) == cur_row, rtag, ref_row, cur_row);
                seen[ref_row] = 1;
                hold_row = ref_row;
                if (served == 0) begin
                    do_insert(0, 5);
                    do_insert(1, 9);
                    do_insert(0, 12);
                    do_insert(1, 12);
                end else if (!cleared && period == 0 && $urandom % 24 == 0) begin
                    do_insert(int'($urandom % 2), int'($urandom % ROWS));
                end
                if (!cleared && period == 2 && cur_epoch == 0 && cur_row == 10) begin
                    do_clear_ins(7);
                    cleared = 1;
                end
                repeat ($urandom % 4) begin
                    @(posedge clk);
                    @(negedge clk);
                end
                ok = ref_req && (int'(ref_row) == hold_row);
                chk(ok, "R8 command held until ack", ref_row, hold_row);
                ref_done = 1'b1;
                @(posedge clk);
                @(negedge clk);
                ref_done = 1'b0;
                served++;
                if (period == 3 && cur_row >= 4) done_run = 1;
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule